// File: doc/BRIEF.md
# Synchronous Buck PWM Gate Controller

This block turns a digital compensation word into the two gate commands of a synchronous buck power stage. An internal phase counter acts as the PWM ramp and sets a fixed switching period. At the start of every period the low-side switch is released, a dead interval passes, and then the high-side switch turns on. The high side turns off when the ramp reaches the compensation word, when the high-side current-limit flag trips, or when the maximum on-time is reached. It never turns off before a minimum on-time has elapsed. After a second dead interval the low side conducts for the rest of the period.

A high-side current-limit trip makes the low side hold on for as long as the low-side current-limit flag stays high. This hold continues past the next period start. The next high-side pulse comes at the first period start after the flag clears. The compensation word is captured once per period, so a word that changes mid-period only affects the following period. Dropping the enable turns both gates off at once.

All inputs are plain level signals sampled on every clock and there is no handshake. The analog error amplifier that produces the compensation word and the power stage itself sit outside this block. With the default parameters (100-clock period, 2-clock dead time, 4-clock minimum and 94-clock maximum on-time) a 50 MHz clock gives a 500 kHz switching rate.

Top module: `buck_pwm_ctrl`

## Requirements
- R1: While `en` is low, and from the first clock edge at which `en` is sampled low, both `hs_gate` and `ls_gate` are 0. After reset both are 0.
- R2: The switching period is PERIOD clocks. After `en` is sampled high, `hs_gate` first goes high on the (DEAD+1)-th clock edge. Every later high-side pulse starts exactly a whole number of periods after that one.
- R3: Within the on-time limits, the high-side pulse lasts `comp_word` − DEAD clocks. The ramp value is the phase count 0..PERIOD−1, and the high side covers phases DEAD up to `comp_word` − 1.
- R4: A high-side pulse is never shorter than MIN_ON clocks. This holds even when `comp_word` ≤ DEAD + MIN_ON or when the high-side current limit is asserted from the pulse's first clock.
- R5: A high-side pulse is never longer than MAX_ON clocks, even when `comp_word` is at or above the period.
- R6: Exactly DEAD clocks with both gates low separate every high-to-low transition and every low-to-high transition.
- R7: `hs_gate` and `ls_gate` are never 1 in the same clock.
- R8: Without a current-limit hold, the low side is on for the rest of the period: PERIOD − 2·DEAD − (high-side width) clocks.
- R9: If `hs_lim` is sampled high during a high-side clock in which the minimum on-time is met, `hs_gate` is 0 from the next edge. The trip has no effect on later periods.
- R10: After a trip, `ls_gate` stays 1 while `ls_lim` is high, across period starts. The next high-side pulse begins at the first period start after `ls_lim` clears, still aligned to the period grid.
- R11: `ls_lim` has no effect when no high-side trip preceded it in the current period. Pulse widths stay as in R3 and R8.
- R12: `comp_word` is captured when a period starts. A change made during the high-side pulse changes only the following period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low forces both gates off |
| comp_word | input | CMP_W | Compensation level compared with the ramp phase |
| hs_lim | input | 1 | High-side over-current flag |
| ls_lim | input | 1 | Low-side current-above-limit flag |
| hs_gate | output | 1 | High-side switch command |
| ls_gate | output | 1 | Low-side switch command |

## Verification
The properties assume that every input is synchronous to `clk` and changes only between edges. They also assume the parameters leave at least one low-side clock per period (MAX_ON + 2·DEAD < PERIOD, DEAD ≥ 1, MIN_ON ≤ MAX_ON). The minimum-on property excuses pulses cut short by a falling `en`, and the hold property applies only while `en` stays high. The stimulus changes `comp_word`, the two limit flags and `en` a fixed delay after a rising edge. It uses only the default parameters and places each flag change at a known pulse position, such as the first high-side clock or the tenth.

// File: rtl/buck_pwm_pkg.sv
`timescale 1ns/1ps
package buck_pwm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_HIGH  = 3'd2,
    ST_TRAIL = 3'd3,
    ST_LOW   = 3'd4
  } gate_st_e;
endpackage

// File: rtl/bpwm_phase_gen.sv
`timescale 1ns/1ps
// Free-running ramp phase; parks on the last phase while disabled so that
// the first enabled edge opens a new period.
module bpwm_phase_gen #(
  parameter int PERIOD = 100,
  localparam int PH_W = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [PH_W-1:0] phase,
  output logic            cyc_end
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= LAST_PH;
    end else if (!en) begin
      phase <= LAST_PH;
    end else if (phase == LAST_PH) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  assign cyc_end = (phase == LAST_PH);
endmodule

// File: rtl/bpwm_ontime.sv
`timescale 1ns/1ps
// Captures the compensation level per period and decides when the
// high-side pulse ends (ramp compare, current limit, on-time bounds).
module bpwm_ontime #(
  parameter int PH_W   = 7,
  parameter int CMP_W  = 8,
  parameter int MIN_ON = 4,
  parameter int MAX_ON = 94,
  localparam int TON_W = $clog2(MAX_ON + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             in_high,
  input  logic             hs_lim,
  input  logic [CMP_W-1:0] comp_word,
  input  logic [PH_W-1:0]  phase,
  output logic             end_high,
  output logic             lim_end
);
  logic [CMP_W-1:0] comp_q;
  logic [TON_W-1:0] ton;
  logic [TON_W:0]   ton_nx;
  logic [CMP_W:0]   ph_nx;
  logic             min_met;
  logic             max_hit;
  logic             ramp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
    end else if (load) begin
      comp_q <= comp_word;
    end
  end

  // ton = high-side clocks already completed in this pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ton <= '0;
    end else if (in_high) begin
      ton <= ton_nx[TON_W-1:0];
    end else begin
      ton <= '0;
    end
  end

  assign ton_nx   = {1'b0, ton} + (TON_W+1)'(1);
  assign ph_nx    = (CMP_W+1)'(phase) + (CMP_W+1)'(1);
  assign ramp_hit = (ph_nx >= {1'b0, comp_q});
  assign max_hit  = (ton_nx >= (TON_W+1)'(MAX_ON));

  generate
    if (MIN_ON <= 1) begin : g_no_min
      assign min_met = 1'b1;
    end else begin : g_min
      assign min_met = (ton_nx >= (TON_W+1)'(MIN_ON));
    end
  endgenerate

  assign lim_end  = in_high && min_met && hs_lim;
  assign end_high = in_high && ((min_met && (ramp_hit || hs_lim)) || max_hit);
endmodule

// File: rtl/bpwm_gate_fsm.sv
`timescale 1ns/1ps
// Gate sequencer: dead intervals on both transitions and the low-side
// hold that follows a high-side current-limit trip.
module bpwm_gate_fsm
  import buck_pwm_pkg::*;
#(
  parameter int DEAD = 2,
  localparam int DW = $clog2(DEAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_end,
  input  logic end_high,
  input  logic lim_end,
  input  logic ls_lim,
  output logic cyc_load,
  output logic lim_latched,
  output logic hs_gate,
  output logic ls_gate
);
  gate_st_e        st;
  logic [DW-1:0]   dcnt;
  logic            dead_done;
  logic            hold_low;

  assign dead_done = (dcnt == DW'(DEAD - 1));
  assign hold_low  = lim_latched && ls_lim;
  assign cyc_load  = en && cyc_end &&
                     ((st == ST_IDLE) || ((st == ST_LOW) && !hold_low));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      dcnt        <= '0;
      lim_latched <= 1'b0;
    end else if (!en) begin
      st          <= ST_IDLE;
      dcnt        <= '0;
      lim_latched <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (cyc_load) begin
            st   <= ST_LEAD;
            dcnt <= '0;
          end
        end
        ST_LEAD: begin
          if (dead_done) begin
            st   <= ST_HIGH;
            dcnt <= '0;
          end else begin
            dcnt <= dcnt + DW'(1);
          end
        end
        ST_HIGH: begin
          if (end_high) begin
            st          <= ST_TRAIL;
            dcnt        <= '0;
            lim_latched <= lim_end;
          end
        end
        ST_TRAIL: begin
          if (dead_done) begin
            st   <= ST_LOW;
            dcnt <= '0;
          end else begin
            dcnt <= dcnt + DW'(1);
          end
        end
        ST_LOW: begin
          if (cyc_load) begin
            st          <= ST_LEAD;
            dcnt        <= '0;
            lim_latched <= 1'b0;
          end else if (lim_latched && !ls_lim) begin
            lim_latched <= 1'b0;
          end
        end
        default: begin
          st   <= ST_IDLE;
          dcnt <= '0;
        end
      endcase
    end
  end

  assign hs_gate = (st == ST_HIGH);
  assign ls_gate = (st == ST_LOW);
endmodule

// File: rtl/buck_pwm_ctrl.sv
`timescale 1ns/1ps
module buck_pwm_ctrl #(
  parameter int PERIOD = 100,
  parameter int CMP_W  = 8,
  parameter int DEAD   = 2,
  parameter int MIN_ON = 4,
  parameter int MAX_ON = 94,
  localparam int PH_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CMP_W-1:0] comp_word,
  input  logic             hs_lim,
  input  logic             ls_lim,
  output logic             hs_gate,
  output logic             ls_gate
);
  logic [PH_W-1:0] phase;
  logic            cyc_end;
  logic            cyc_load;
  logic            end_high;
  logic            lim_end;
  logic            lim_latched;

  bpwm_phase_gen #(.PERIOD(PERIOD)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .phase   (phase),
    .cyc_end (cyc_end)
  );

  bpwm_ontime #(
    .PH_W   (PH_W),
    .CMP_W  (CMP_W),
    .MIN_ON (MIN_ON),
    .MAX_ON (MAX_ON)
  ) u_ontime (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cyc_load),
    .in_high   (hs_gate),
    .hs_lim    (hs_lim),
    .comp_word (comp_word),
    .phase     (phase),
    .end_high  (end_high),
    .lim_end   (lim_end)
  );

  bpwm_gate_fsm #(.DEAD(DEAD)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .cyc_end     (cyc_end),
    .end_high    (end_high),
    .lim_end     (lim_end),
    .ls_lim      (ls_lim),
    .cyc_load    (cyc_load),
    .lim_latched (lim_latched),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate)
  );
endmodule

// File: rtl/buck_pwm_ctrl_chk.sv
`timescale 1ns/1ps
module buck_pwm_ctrl_chk #(
  parameter int DEAD   = 2,
  parameter int MIN_ON = 4,
  parameter int MAX_ON = 94
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic hs_lim,
  input logic ls_lim,
  input logic hs_gate,
  input logic ls_gate,
  input logic lim_latched
);
  logic [15:0] idle_run;
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_run <= '0;
      hi_run   <= '0;
    end else begin
      if (hs_gate || ls_gate) idle_run <= '0;
      else if (idle_run != 16'hFFFF) idle_run <= idle_run + 16'd1;
      if (!hs_gate) hi_run <= '0;
      else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
    end
  end

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_gate && !ls_gate)); // R1
  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_gate) && $past(en)) |-> (int'(hi_run) >= MIN_ON)); // R4
  AST_MAX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> (int'(hi_run) < MAX_ON)); // R5
  AST_DEAD_BEFORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (int'(idle_run) >= DEAD)); // R6
  AST_DEAD_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> (int'(idle_run) >= DEAD)); // R6
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate)); // R7
  AST_LIMIT_CUTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && hs_lim && (int'(hi_run) + 1 >= MIN_ON)) |=> !hs_gate); // R9
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lim_latched && ls_lim && ls_gate) |=> (ls_gate || !en)); // R10
endmodule

bind buck_pwm_ctrl buck_pwm_ctrl_chk #(
  .DEAD   (DEAD),
  .MIN_ON (MIN_ON),
  .MAX_ON (MAX_ON)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .hs_lim      (hs_lim),
  .ls_lim      (ls_lim),
  .hs_gate     (hs_gate),
  .ls_gate     (ls_gate),
  .lim_latched (lim_latched)
);

// File: tb/buck_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module buck_pwm_ctrl_tb_top;
  localparam int PERIOD = 100;
  localparam int DEAD   = 2;
  localparam int MIN_ON = 4;
  localparam int MAX_ON = 94;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] comp;
  logic       hs_lim;
  logic       ls_lim;
  logic       hs;
  logic       ls;

  int n_vec = 0;
  int n_bad = 0;
  int tick = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  buck_pwm_ctrl #(
    .PERIOD(PERIOD), .CMP_W(8), .DEAD(DEAD), .MIN_ON(MIN_ON), .MAX_ON(MAX_ON)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .comp_word(comp),
    .hs_lim(hs_lim), .ls_lim(ls_lim), .hs_gate(hs), .ls_gate(ls)
  );

  task automatic step();
    @(posedge clk);
    #5;
    tick++;
    if (hs && ls) overlap++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_w(input int c);
    int w;
    w = c - DEAD;
    if (w < MIN_ON) w = MIN_ON;
    if (w > MAX_ON) w = MAX_ON;
    return w;
  endfunction

  task automatic wait_rise();
    int g = 0;
    while (!hs && g < 1000) begin step(); g++; end
  endtask

  task automatic count_high(output int hw);
    hw = 0;
    while (hs && hw < 1000) begin hw++; step(); end
  endtask

  task automatic count_rest(output int dd, output int lw, output int du);
    dd = 0; lw = 0; du = 0;
    while (!hs && !ls && dd < 1000) begin dd++; step(); end
    while (ls && lw < 1000) begin lw++; step(); end
    while (!hs && !ls && du < 1000) begin du++; step(); end
  endtask

  task automatic measure(output int hw, output int dd, output int lw, output int du);
    wait_rise();
    count_high(hw);
    count_rest(dd, lw, du);
  endtask

  task automatic t_reset();
    chk(!hs && !ls, "R1 reset gates", {hs, ls}, 0);
    repeat (10) step();
    chk(!hs && !ls, "R1 disabled gates", {hs, ls}, 0);
  endtask

  task automatic t_start();
    int hw, dd, lw, du;
    comp = 8'd50;
    en = 1'b1;
    step(); step();
    chk(!hs && !ls, "R2 lead dead", {hs, ls}, 0);
    step();
    chk(hs, "R2 first high edge", hs, 1);
    measure(hw, dd, lw, du);
    chk(hw == 48, "R3 width comp=50", hw, 48);
    chk(dd == DEAD, "R6 trailing dead", dd, DEAD);
    chk(lw == 48, "R8 low width", lw, 48);
    chk(du == DEAD, "R6 leading dead", du, DEAD);
    chk(hw + dd + lw + du == PERIOD, "R2 period", hw + dd + lw + du, PERIOD);
  endtask

  task automatic t_width(input int c, input string req);
    int hw, dd, lw, du;
    comp = 8'(c);
    measure(hw, dd, lw, du);
    measure(hw, dd, lw, du);
    chk(hw == exp_w(c), req, hw, exp_w(c));
    chk(lw == PERIOD - 2*DEAD - hw, "R8 low remainder", lw, PERIOD - 2*DEAD - hw);
  endtask

  task automatic t_midcycle();
    int hw, dd, lw, du;
    t_width(50, "R3 width comp=50");
    comp = 8'd20;
    count_high(hw);
    count_rest(dd, lw, du);
    chk(hw == 48, "R12 current period keeps old word", hw, 48);
    measure(hw, dd, lw, du);
    chk(hw == 18, "R12 next period uses new word", hw, 18);
  endtask

  task automatic t_trip_late();
    int hw, dd, lw, du;
    t_width(80, "R3 width comp=80");
    repeat (9) step();
    chk(hs, "R9 high before trip", hs, 1);
    hs_lim = 1'b1;
    step();
    chk(!hs, "R9 trip ends high", hs, 0);
    hs_lim = 1'b0;
    count_rest(dd, lw, du);
    chk(dd == DEAD, "R6 dead after trip", dd, DEAD);
    chk(lw == 86, "R8 low after trip", lw, 86);
    count_high(hw);
    count_rest(dd, lw, du);
    chk(hw == 78, "R9 next period unaffected", hw, 78);
  endtask

  task automatic t_trip_hold();
    int hw, dd, t_ref, t_clr, bad;
    t_ref = tick;
    hs_lim = 1'b1;
    ls_lim = 1'b1;
    count_high(hw);
    chk(hw == MIN_ON, "R4 min on under limit", hw, MIN_ON);
    hs_lim = 1'b0;
    dd = 0;
    while (!hs && !ls && dd < 1000) begin dd++; step(); end
    chk(dd == DEAD, "R6 dead before held low", dd, DEAD);
    bad = 0;
    repeat (150) begin
      if (!(ls && !hs)) bad++;
      step();
    end
    chk(bad == 0, "R10 low held past period start", bad, 0);
    ls_lim = 1'b0;
    t_clr = tick;
    wait_rise();
    chk(((tick - t_ref) % PERIOD) == 0, "R10 resume on period grid",
        (tick - t_ref) % PERIOD, 0);
    chk((tick - t_clr) <= PERIOD, "R10 resume at first start",
        tick - t_clr, PERIOD);
    count_high(hw);
    chk(hw == 78, "R10 normal width after hold", hw, 78);
    wait_rise();
  endtask

  task automatic t_ls_ignored();
    int hw, dd, lw, du;
    ls_lim = 1'b1;
    count_high(hw);
    count_rest(dd, lw, du);
    ls_lim = 1'b0;
    chk(hw == 78, "R11 high width with ls flag", hw, 78);
    chk(lw == 18, "R11 low width with ls flag", lw, 18);
  endtask

  task automatic t_disable();
    int bad = 0;
    en = 1'b0;
    step();
    chk(!hs && !ls, "R1 off after disable", {hs, ls}, 0);
    repeat (20) begin
      if (hs || ls) bad++;
      step();
    end
    chk(bad == 0, "R1 stays off", bad, 0);
    en = 1'b1;
    step(); step();
    chk(!hs && !ls, "R2 restart lead dead", {hs, ls}, 0);
    step();
    chk(hs, "R2 restart high edge", hs, 1);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; comp = '0; hs_lim = 1'b0; ls_lim = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_start();
    t_width(30, "R3 width comp=30");
    t_width(3, "R4 min on comp=3");
    t_width(0, "R4 min on comp=0");
    t_width(96, "R5 max on boundary");
    t_width(200, "R5 max on clamp");
    t_midcycle();
    t_trip_late();
    t_trip_hold();
    t_ls_ignored();
    t_disable();
    chk(overlap == 0, "R7 gates overlap", overlap, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", tick, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule